// File: doc/BRIEF.md
# Flow Classification Hash Unit

This unit turns a 352-bit flow tuple into a single 32-bit hash word that a packet classifier uses to place or find a filter. The tuple is eleven 32-bit words. Word 0 holds the flow type, the pool and the packet type. Words 1 to 10 hold the addresses, the ports and the remaining match fields. Word `n` sits at bits `[32n+31:32n]` of `tuple_in`, and each word is taken as a plain number.

The same keyed XOR-fold runs twice on each tuple. The first pass uses the bucket key and gives a bucket index. That index is masked to 13, 14 or 15 bits, depending on how large the filter memory is configured. The second pass uses the signature key and gives a 16-bit signature.

The result is packed into one word in one of two ways:
- **Signature mode:** the word holds the signature and the bucket.
- **Perfect mode:** the word holds a software filter index and the bucket.

A two-state machine controls the edge of the block. In `ST_IDLE` the unit accepts a tuple with a valid/ready handshake (transition *accept*). In `ST_HASH` it computes the result and registers it (transition *finish*, always back to `ST_IDLE`). Filter storage and lookup live outside this block.

Top module: `flow_hash_unit`

## Requirements
- R1: After reset, `hash_word` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 only in `ST_IDLE`. After a transfer is accepted (`in_valid && in_ready` at a clock edge), `in_ready` is 0 for exactly one cycle. A tuple offered while `in_ready` is 0 is not taken.
- R3: The result of an accepted tuple appears on `hash_word` one clock edge after acceptance. `out_valid` is high for exactly that one cycle.
- R4: `hash_word` keeps its value between results, whatever the inputs do.
- R5: The fold works as follows:
  - C is the XOR of words 1 to 10.
  - H = C ^ w0 ^ (w0 >> 16).
  - L0 is C with its 16-bit halves swapped.
  - L = L0 ^ w0 ^ (w0 << 16).
  - A zero key gives a zero hash.
- R6: Key bit 0 XORs L0 into the result. This is the low word before the word-0 mix. Key bit 16 XORs H into the result.
- R7: For i = 1 to 15, key bit i XORs (L >> i) into the result, and key bit i+16 XORs (H >> i) into the result. All arithmetic is 32-bit.
- R8: `size_sel` sets how many low bits of the bucket hash are kept:

  | `size_sel` | Bucket bits kept |
  |---|---|
  | 2'b00 | 13 |
  | 2'b01 | 14 |
  | 2'b10 | 15 |
  | 2'b11 | 13 |

  The kept bits sit in `hash_word[14:0]`, and the unused bucket bits above them read 0.
- R9: With `sig_mode`=1, `hash_word[31:16]` is the low 16 bits of the signature-key hash, and bit 15 is 0.
- R10: With `sig_mode`=0, `hash_word[31:16]` is `soft_idx`, bit 15 is 0, and the signature key has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A tuple is offered |
| in_ready | output | 1 | Unit can take a tuple |
| tuple_in | input | 352 | Flow tuple, word n at [32n+31:32n] |
| bkt_key | input | 32 | Key for the bucket pass |
| sig_key | input | 32 | Key for the signature pass |
| sig_mode | input | 1 | 1 = signature packing, 0 = perfect packing |
| size_sel | input | 2 | Filter memory size select |
| soft_idx | input | 16 | Software filter index, used in perfect mode |
| out_valid | output | 1 | One-cycle pulse when a new result is registered |
| hash_word | output | 32 | Packed hash result |

## Verification
The bench drives tuples that are zero except for word 0, so the order of the word-0 mixing becomes visible:
- With key bit 0 alone, the bucket must be 0. A design that mixes word 0 in before applying bit 0 returns the word-0 pattern instead.
- With key bit 16 alone, the result must show the high-half mix. A design that leaves out the mix, or uses the wrong shift direction, returns 0 or the unshifted word.

The bench also checks every `size_sel` code. A wrong mask width leaks bits into position 13 or 14, or drops them.

Two further cases cover the handshake and hold behaviour:
- A tuple is held valid while the unit is busy. A design that samples during `ST_HASH` reports the second tuple's hash in the first result slot.
- The inputs are changed while the unit is idle. A design that updates its output register without a handshake loses the stored result.

// File: rtl/flow_hash_pkg.sv
package flow_hash_pkg;
    localparam int TUPLE_WORDS = 11;
    localparam int WORD_W      = 32;
    localparam int SIG_W       = 16;
    localparam int BKT_MAX_W   = 15;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HASH = 1'b1
    } fh_state_e;

    typedef enum logic [1:0] {
        SZ_SMALL = 2'b00,
        SZ_MID   = 2'b01,
        SZ_LARGE = 2'b10,
        SZ_ALT   = 2'b11
    } fh_size_e;
endpackage

// File: rtl/fh_fold_core.sv
module fh_fold_core #(
    parameter int N_WORDS = 11,
    parameter int W       = 32,
    parameter int OUT_W   = 16
) (
    input  logic [N_WORDS*W-1:0] tuple,
    input  logic [W-1:0]         key,
    output logic [OUT_W-1:0]     hash_out
);
    localparam int HALF = W / 2;

    logic [W-1:0] common;
    logic [W-1:0] w0;
    logic [W-1:0] hi_w;
    logic [W-1:0] lo_pre;
    logic [W-1:0] lo_w;
    logic [W-1:0] term [HALF];
    logic [W-1:0] acc;

    always_comb begin
        common = '0;
        for (int k = 1; k < N_WORDS; k++) begin
            common = common ^ tuple[k*W +: W];
        end
    end

    assign w0     = tuple[W-1:0];
    assign hi_w   = common ^ w0 ^ (w0 >> HALF);
    assign lo_pre = {common[HALF-1:0], common[W-1:HALF]};
    // word-0 mix enters the low word only after key bit 0 has used lo_pre
    assign lo_w   = lo_pre ^ w0 ^ (w0 << HALF);

    genvar gi;
    generate
        for (gi = 0; gi < HALF; gi++) begin : g_term
            if (gi == 0) begin : g_first
                assign term[gi] = (key[0] ? lo_pre : '0) ^ (key[HALF] ? hi_w : '0);
            end else begin : g_rest
                assign term[gi] = (key[gi] ? (lo_w >> gi) : '0)
                                ^ (key[gi+HALF] ? (hi_w >> gi) : '0);
            end
        end
    endgenerate

    always_comb begin
        acc = '0;
        for (int k = 0; k < HALF; k++) begin
            acc = acc ^ term[k];
        end
    end

    assign hash_out = OUT_W'(acc);
endmodule

// File: rtl/fh_bkt_mask.sv
module fh_bkt_mask #(
    parameter int BKT_MAX = 15
) (
    input  logic [BKT_MAX-1:0] bkt_in,
    input  logic [1:0]         size_sel,
    output logic [BKT_MAX-1:0] bkt_out
);
    import flow_hash_pkg::*;

    localparam logic [BKT_MAX-1:0] MASK_LARGE = '1;
    localparam logic [BKT_MAX-1:0] MASK_MID   = MASK_LARGE >> 1;
    localparam logic [BKT_MAX-1:0] MASK_SMALL = MASK_LARGE >> 2;

    logic [BKT_MAX-1:0] mask;

    always_comb begin
        unique case (fh_size_e'(size_sel))
            SZ_MID:   mask = MASK_MID;
            SZ_LARGE: mask = MASK_LARGE;
            SZ_SMALL: mask = MASK_SMALL;
            SZ_ALT:   mask = MASK_SMALL;
        endcase
    end

    assign bkt_out = bkt_in & mask;
endmodule

// File: rtl/fh_pack.sv
module fh_pack #(
    parameter int W       = 32,
    parameter int SIG_W   = 16,
    parameter int BKT_MAX = 15
) (
    input  logic               sig_mode,
    input  logic [SIG_W-1:0]   sig_val,
    input  logic [SIG_W-1:0]   idx_val,
    input  logic [BKT_MAX-1:0] bkt_val,
    output logic [W-1:0]       word
);
    localparam int GAP = W - SIG_W - BKT_MAX;

    assign word = {(sig_mode ? sig_val : idx_val), {GAP{1'b0}}, bkt_val};
endmodule

// File: rtl/flow_hash_unit.sv
module flow_hash_unit #(
    parameter int N_WORDS = flow_hash_pkg::TUPLE_WORDS,
    parameter int W       = flow_hash_pkg::WORD_W,
    parameter int SIG_W   = flow_hash_pkg::SIG_W,
    parameter int BKT_MAX = flow_hash_pkg::BKT_MAX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [N_WORDS*W-1:0] tuple_in,
    input  logic [W-1:0]         bkt_key,
    input  logic [W-1:0]         sig_key,
    input  logic                 sig_mode,
    input  logic [1:0]           size_sel,
    input  logic [SIG_W-1:0]     soft_idx,
    output logic                 out_valid,
    output logic [W-1:0]         hash_word
);
    import flow_hash_pkg::*;

    localparam int TUPLE_W = N_WORDS * W;

    fh_state_e state_q, state_d;

    logic [TUPLE_W-1:0] tuple_q;
    logic [W-1:0]       bkt_key_q, sig_key_q;
    logic               mode_q;
    logic [1:0]         size_q;
    logic [SIG_W-1:0]   idx_q;

    logic [SIG_W-1:0]   bkt_raw, sig_raw;
    logic [BKT_MAX-1:0] bkt_masked;
    logic [W-1:0]       packed_word;
    logic               accept;

    assign in_ready = (state_q == ST_IDLE);
    assign accept   = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_HASH;
            ST_HASH: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tuple_q   <= '0;
            bkt_key_q <= '0;
            sig_key_q <= '0;
            mode_q    <= 1'b0;
            size_q    <= 2'b00;
            idx_q     <= '0;
            hash_word <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    tuple_q   <= tuple_in;
                    bkt_key_q <= bkt_key;
                    sig_key_q <= sig_key;
                    mode_q    <= sig_mode;
                    size_q    <= size_sel;
                    idx_q     <= soft_idx;
                end
                ST_HASH: begin
                    hash_word <= packed_word;
                    out_valid <= 1'b1;
                end
            endcase
        end
    end

    fh_fold_core #(.N_WORDS(N_WORDS), .W(W), .OUT_W(SIG_W)) u_bkt_core (
        .tuple(tuple_q), .key(bkt_key_q), .hash_out(bkt_raw)
    );

    fh_fold_core #(.N_WORDS(N_WORDS), .W(W), .OUT_W(SIG_W)) u_sig_core (
        .tuple(tuple_q), .key(sig_key_q), .hash_out(sig_raw)
    );

    fh_bkt_mask #(.BKT_MAX(BKT_MAX)) u_mask (
        .bkt_in(BKT_MAX'(bkt_raw)), .size_sel(size_q), .bkt_out(bkt_masked)
    );

    fh_pack #(.W(W), .SIG_W(SIG_W), .BKT_MAX(BKT_MAX)) u_pack (
        .sig_mode(mode_q), .sig_val(sig_raw), .idx_val(idx_q),
        .bkt_val(bkt_masked), .word(packed_word)
    );

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R3
    result_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready, 2));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(hash_word));
endmodule

// File: tb/flow_hash_unit_tb.sv
module flow_hash_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [351:0] tuple_in = '0;
    logic [31:0]  bkt_key = '0;
    logic [31:0]  sig_key = '0;
    logic         sig_mode = 1'b0;
    logic [1:0]   size_sel = 2'b00;
    logic [15:0]  soft_idx = '0;
    logic         out_valid;
    logic [31:0]  hash_word;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    flow_hash_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .tuple_in(tuple_in), .bkt_key(bkt_key), .sig_key(sig_key),
        .sig_mode(sig_mode), .size_sel(size_sel), .soft_idx(soft_idx),
        .out_valid(out_valid), .hash_word(hash_word)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_hash(input logic [351:0] t, input logic [31:0] k);
        logic [31:0] c, hi, lo, r, w0;
        c = '0;
        for (int n = 1; n < 11; n++) c ^= t[n*32 +: 32];
        w0 = t[31:0];
        hi = c ^ w0 ^ (w0 >> 16);
        lo = {c[15:0], c[31:16]};
        r = '0;
        if (k[0])  r ^= lo;
        if (k[16]) r ^= hi;
        lo ^= w0 ^ (w0 << 16);
        for (int i = 15; i >= 1; i--) begin
            if (k[i])    r ^= lo >> i;
            if (k[i+16]) r ^= hi >> i;
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_word(input logic [351:0] t, input logic [31:0] bk,
            input logic [31:0] sk, input logic md, input logic [1:0] sel, input logic [15:0] idx);
        logic [31:0] b, s;
        int bw;
        bw = (sel == 2'b01) ? 14 : (sel == 2'b10) ? 15 : 13;
        b = ref_hash(t, bk) & ((32'd1 << bw) - 1);
        s = ref_hash(t, sk);
        return {(md ? s[15:0] : idx), 1'b0, b[14:0]};
    endfunction

    function automatic logic [351:0] make_tuple(input logic [31:0] seed);
        logic [351:0] t;
        for (int n = 0; n < 11; n++) t[n*32 +: 32] = (seed + 32'(n)) * 32'h9E3779B1 ^ (seed << n);
        return t;
    endfunction

    task automatic run_one(input logic [351:0] t, input logic [31:0] bk, input logic [31:0] sk,
            input logic md, input logic [1:0] sel, input logic [15:0] idx, input string req);
        logic [31:0] exp;
        exp = ref_word(t, bk, sk, md, sel, idx);
        @(negedge clk);
        tuple_in = t; bkt_key = bk; sig_key = sk; sig_mode = md; size_sel = sel; soft_idx = idx;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R2 busy after accept", {31'd0, in_ready}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b1, "R3 out_valid pulse", {31'd0, out_valid}, 32'd1);
        check(hash_word == exp, req, hash_word, exp);
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R3 pulse ends", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(hash_word == 32'd0, "R1 hash reset", hash_word, 32'd0);
        check(out_valid == 1'b0, "R1 out_valid reset", {31'd0, out_valid}, 32'd0);
        check(in_ready == 1'b1, "R1 ready reset", {31'd0, in_ready}, 32'd1);
    endtask

    task automatic t_signature();
        run_one(make_tuple(32'h1),  32'h3DAD14E2, 32'h174D3614, 1'b1, 2'b00, 16'h0, "R5 R7 R9 sig tuple A");
        run_one(make_tuple(32'h77), 32'hFFFFFFFF, 32'h80000001, 1'b1, 2'b00, 16'h0, "R7 R9 sig tuple B");
        run_one(make_tuple(32'hC0DE), 32'h0000FFFE, 32'hFFFE0000, 1'b1, 2'b00, 16'h0, "R7 R9 sig tuple C");
    endtask

    task automatic t_perfect();
        run_one(make_tuple(32'h5), 32'h3DAD14E2, 32'h174D3614, 1'b0, 2'b10, 16'hABCD, "R10 perfect idx");
        run_one(make_tuple(32'h5), 32'h3DAD14E2, 32'h00000000, 1'b0, 2'b10, 16'hABCD, "R10 sig key no effect");
    endtask

    task automatic t_sizes();
        run_one(make_tuple(32'h9), 32'hFFFFFFFF, 32'h1, 1'b1, 2'b00, 16'h0, "R8 size 00");
        run_one(make_tuple(32'h9), 32'hFFFFFFFF, 32'h1, 1'b1, 2'b01, 16'h0, "R8 size 01");
        run_one(make_tuple(32'h9), 32'hFFFFFFFF, 32'h1, 1'b1, 2'b10, 16'h0, "R8 size 10");
        run_one(make_tuple(32'h9), 32'hFFFFFFFF, 32'h1, 1'b1, 2'b11, 16'h0, "R8 size 11");
    endtask

    task automatic t_key_order();
        logic [351:0] t;
        t = '0;
        t[31:0] = 32'h0000_0005;
        run_one(t, 32'h0000_0001, 32'h0000_0001, 1'b1, 2'b10, 16'h0, "R6 bit0 before word0 mix");
        check(hash_word == 32'h0, "R6 bit0 zero result", hash_word, 32'h0);
        t[31:0] = 32'h0005_0000;
        run_one(t, 32'h0001_0000, 32'h0001_0000, 1'b1, 2'b00, 16'h0, "R6 bit16 high mix");
        check(hash_word == 32'h0005_0005, "R6 bit16 literal", hash_word, 32'h0005_0005);
        run_one(make_tuple(32'h33), 32'h0, 32'h0, 1'b1, 2'b10, 16'h0, "R5 zero key");
        check(hash_word == 32'h0, "R5 zero key literal", hash_word, 32'h0);
    endtask

    task automatic t_hold();
        logic [31:0] held;
        held = hash_word;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            tuple_in = make_tuple(32'(c) + 32'h400);
            bkt_key = ~bkt_key; sig_mode = ~sig_mode; soft_idx = soft_idx + 16'h111;
        end
        @(negedge clk);
        check(hash_word == held, "R4 hold without handshake", hash_word, held);
        check(out_valid == 1'b0, "R4 no pulse without handshake", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_busy();
        logic [351:0] ta, tb;
        logic [31:0] ea, eb;
        ta = make_tuple(32'hA1); tb = make_tuple(32'hB2);
        ea = ref_word(ta, 32'h12345678, 32'h9ABCDEF0, 1'b1, 2'b10, 16'h0);
        eb = ref_word(tb, 32'h12345678, 32'h9ABCDEF0, 1'b1, 2'b10, 16'h0);
        @(negedge clk);
        bkt_key = 32'h12345678; sig_key = 32'h9ABCDEF0; sig_mode = 1'b1; size_sel = 2'b10;
        tuple_in = ta; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tuple_in = tb;
        check(in_ready == 1'b0, "R2 not ready while busy", {31'd0, in_ready}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        check(hash_word == ea, "R2 busy offer not taken", hash_word, ea);
        check(in_ready == 1'b1, "R2 ready again", {31'd0, in_ready}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(hash_word == eb, "R2 second tuple result", hash_word, eb);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_signature();
        t_perfect();
        t_sizes();
        t_key_order();
        t_hold();
        t_busy();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule